// File: doc/BRIEF.md
# Add/Subtract Unit with Condition Flags

This block adds or subtracts two 64-bit operands in one pass of combinational logic and reports the four condition flags that go with the result: negative, zero, carry and overflow. A size select chooses between full-width operation and half-width (32-bit) operation. In half-width mode the upper halves of both operands are disregarded, every flag is taken from the 32-bit result, and the 64-bit result carries that 32-bit value zero-extended.

For subtraction the carry flag is the "no borrow" indication: it is 1 when the first operand, read as unsigned, is at least as large as the second. A flag-enable input marks the operations whose flags should be kept. On each clock edge with the enable high, the flags are captured into a 4-bit register, and a one-cycle write strobe follows so that a consumer can see a fresh capture. With the enable low the register keeps its contents, while the arithmetic result is still produced as usual.

Top module: `addsub_nzcv`

## Requirements
- R1: With op_sub=0, result is opa+opb at the selected width, and flag_c is the carry out of that unsigned sum (bit 64 in full-width mode, bit 32 in half-width mode).
- R2: With op_sub=1, result is opa-opb at the selected width, and flag_c is 1 exactly when opa is unsigned greater than or equal to opb at that width.
- R3: With wide=0, only opa[31:0] and opb[31:0] affect any output, and result[63:32] is zero.
- R4: flag_n is the sign bit of the selected-width result (bit 63 or bit 31); flag_z is 1 exactly when the selected-width result is zero.
- R5: flag_v is 1 when signed overflow occurs: for addition, both operands share a sign and the result has the other; for subtraction, the operands differ in sign and the result's sign differs from opa's.
- R6: On a rising clock edge with flag_en=1, nzcv_q loads {N,Z,C,V} in bits 3 down to 0.
- R7: On a rising clock edge with flag_en=0, nzcv_q keeps its value, while result and the combinational flags still follow the inputs.
- R8: nzcv_wr is 1 for the cycle after an edge at which flag_en was 1, and 0 otherwise.
- R9: While rst_n is low, nzcv_q is 0000 and nzcv_wr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_sub | input | 1 | 0 adds, 1 subtracts opb from opa |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| flag_en | input | 1 | Capture the flags at the next edge |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| result | output | DATA_W | Sum or difference, zero-extended in 32-bit mode |
| flag_n | output | 1 | Negative flag, combinational |
| flag_z | output | 1 | Zero flag, combinational |
| flag_c | output | 1 | Carry / no-borrow flag, combinational |
| flag_v | output | 1 | Signed overflow flag, combinational |
| nzcv_q | output | 4 | Captured flags {N,Z,C,V} |
| nzcv_wr | output | 1 | Strobe: nzcv_q was written at the last edge |

## Verification
The result and the four combinational flags are due in the same cycle the operands are applied, and the captured flags and write strobe are due one clock edge later. The driver applies each operation at a falling edge and queues its expectation, and the monitor checks both the combinational values and the registered ones one time unit after the following rising edge, while the operands are still held. Operand corners (zero, all-ones, most negative, most positive) are crossed at both widths and both operations, with junk in the upper halves during 32-bit runs and the enable dropped on a regular pattern to exercise the hold.

// File: rtl/addsub_nzcv.sv
module addsub_nzcv #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_sub,
  input  logic              wide,
  input  logic              flag_en,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic [3:0]        nzcv_q,
  output logic              nzcv_wr
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;
  logic [HALF_W:0]   sum_h;
  logic              sgn_a, sgn_b, sgn_r;

  assign b_eff = op_sub ? ~opb : opb;
  assign sum_w = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, op_sub};
  assign sum_h = {1'b0, opa[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
               + {{HALF_W{1'b0}}, op_sub};

  assign result = wide ? sum_w[DATA_W-1:0] : {{(DATA_W-HALF_W){1'b0}}, sum_h[HALF_W-1:0]};

  assign sgn_a = wide ? opa[DATA_W-1]     : opa[HALF_W-1];
  assign sgn_b = wide ? opb[DATA_W-1]     : opb[HALF_W-1];
  assign sgn_r = wide ? sum_w[DATA_W-1]   : sum_h[HALF_W-1];

  assign flag_n = sgn_r;
  assign flag_z = wide ? (sum_w[DATA_W-1:0] == '0) : (sum_h[HALF_W-1:0] == '0);
  assign flag_c = wide ? sum_w[DATA_W] : sum_h[HALF_W];
  assign flag_v = (sgn_r ^ sgn_a) & (op_sub ? (sgn_a ^ sgn_b) : ~(sgn_a ^ sgn_b));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nzcv_q  <= 4'b0000;
      nzcv_wr <= 1'b0;
    end else begin
      nzcv_wr <= flag_en;
      if (flag_en) nzcv_q <= {flag_n, flag_z, flag_c, flag_v};
    end
  end

  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> result[DATA_W-1:HALF_W] == '0);  // R3
  AST_SUB_NOBORROW: assert property (@(posedge clk) disable iff (!rst_n)
    op_sub |-> flag_c == (wide ? (opa >= opb) : (opa[HALF_W-1:0] >= opb[HALF_W-1:0])));  // R2
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z == (result == '0));  // R4
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> nzcv_q == $past({flag_n, flag_z, flag_c, flag_v}));  // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> $stable(nzcv_q));  // R7
  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    flag_en |=> nzcv_wr);  // R8
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |=> !nzcv_wr);  // R8
  always_comb begin
    if (!rst_n) AST_RESET_STATE: assert (nzcv_q == 4'b0000 && !nzcv_wr);  // R9
  end
endmodule

// File: tb/addsub_nzcv_tb.sv
module addsub_nzcv_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_sub = 1'b0, wide = 1'b1, flag_en = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [63:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [3:0]  nzcv_q;
  logic        nzcv_wr;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic [3:0]  f;
    logic [3:0]  q;
    logic        wr;
    logic        sub;
    logic        wd;
    logic        en;
  } item_t;
  item_t sb[$];
  logic [3:0] model_q = 4'b0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  addsub_nzcv #(.DATA_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_sub(op_sub), .wide(wide), .flag_en(flag_en),
    .opa(opa), .opb(opb), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .nzcv_q(nzcv_q), .nzcv_wr(nzcv_wr));

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void ref_model(input logic sub, input logic wd, input logic [63:0] a,
                                    input logic [63:0] b, output logic [63:0] r, output logic [3:0] f);
    logic n, z, c, v, sa, sb2, sr;
    if (wd) begin
      logic [64:0] t;
      if (sub) begin r = a - b; c = (a >= b); end
      else begin t = {1'b0, a} + {1'b0, b}; r = t[63:0]; c = t[64]; end
      sa = a[63]; sb2 = b[63]; sr = r[63];
    end else begin
      logic [31:0] a32, b32, r32;
      logic [32:0] t;
      a32 = a[31:0]; b32 = b[31:0];
      if (sub) begin r32 = a32 - b32; c = (a32 >= b32); end
      else begin t = {1'b0, a32} + {1'b0, b32}; r32 = t[31:0]; c = t[32]; end
      r = {32'h0, r32};
      sa = a32[31]; sb2 = b32[31]; sr = r32[31];
    end
    n = sr;
    z = (r == 64'h0);
    if (sub) v = (sa != sb2) && (sr != sa);
    else     v = (sa == sb2) && (sr != sa);
    f = {n, z, c, v};
  endfunction

  task automatic drive(input logic sub, input logic wd, input logic en,
                       input logic [63:0] a, input logic [63:0] b);
    item_t it;
    @(negedge clk);
    op_sub = sub; wide = wd; flag_en = en; opa = a; opb = b;
    ref_model(sub, wd, a, b, it.res, it.f);
    if (en) model_q = it.f;
    it.q = model_q; it.wr = en; it.sub = sub; it.wd = wd; it.en = en;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        it = sb.pop_front();
        check(result == it.res, it.wd ? (it.sub ? "R2 result" : "R1 result") : "R3 result",
              result, it.res);
        check(flag_n == it.f[3], "R4 N", 64'(flag_n), 64'(it.f[3]));
        check(flag_z == it.f[2], "R4 Z", 64'(flag_z), 64'(it.f[2]));
        check(flag_c == it.f[1], it.sub ? "R2 C" : "R1 C", 64'(flag_c), 64'(it.f[1]));
        check(flag_v == it.f[0], "R5 V", 64'(flag_v), 64'(it.f[0]));
        check(nzcv_q == it.q, it.en ? "R6 load" : "R7 hold", 64'(nzcv_q), 64'(it.q));
        check(nzcv_wr == it.wr, "R8 strobe", 64'(nzcv_wr), 64'(it.wr));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [63:0] c64 [4];
    logic [31:0] c32 [4];
    c64[0] = 64'h0; c64[1] = '1; c64[2] = 64'h8000_0000_0000_0000; c64[3] = 64'h7FFF_FFFF_FFFF_FFFF;
    c32[0] = 32'h0; c32[1] = '1; c32[2] = 32'h8000_0000;           c32[3] = 32'h7FFF_FFFF;

    repeat (2) @(negedge clk);
    #1;
    check(nzcv_q == 4'b0000, "R9 reset nzcv_q", 64'(nzcv_q), 64'h0);
    check(nzcv_wr == 1'b0, "R9 reset nzcv_wr", 64'(nzcv_wr), 64'h0);
    rst_n = 1'b1;

    drive(1'b0, 1'b1, 1'b1, 64'd1, 64'd1);
    drive(1'b1, 1'b1, 1'b1, 64'd5, 64'd7);
    drive(1'b1, 1'b1, 1'b0, 64'd7, 64'd7);
    drive(1'b1, 1'b0, 1'b1, 64'hFFFF_0000_0000_0009, 64'h0000_1111_0000_0009);

    for (int s = 0; s < 2; s++)
      for (int w = 0; w < 2; w++)
        for (int i = 0; i < 4; i++)
          for (int j = 0; j < 4; j++) begin
            logic [63:0] a, b;
            if (w == 1) begin a = c64[i]; b = c64[j]; end
            else begin
              a = {32'hDEAD_BEEF ^ 32'(i * 32'h1357_9BDF), c32[i]};
              b = {32'hA5A5_5A5A ^ 32'(j * 32'h2468_ACE1), c32[j]};
            end
            drive(s[0], w[0], ((i + j) % 4) != 3, a, b);
          end

    @(negedge clk);
    flag_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule